// File: doc/BRIEF.md
# Pixel Clock Divider Search

This block picks the settings of a fractional pixel clock path: given a requested dot clock in kHz, it finds a PLL multiplier `n`, a post-divider `m` and a doubler flag. With these settings the delivered clock is `unit * n / m`, where `unit` is 3000 kHz on the plain path and 6000 kHz on the doubled path. The chosen clock is the closest one that does not exceed the request. A controller raises `start_i` with the target on `target_khz_i`. Some cycles later it sees a one-cycle `done_o` together with the settings, or with `none_o` if no setting is legal. The PLL is then programmed to `n * 3 MHz`.

The search walks the divider downward from 15 to 1. For each divider it evaluates the plain path first and the doubled path second. One shared restoring divider does both divisions of every candidate: first the multiplier, then the frequency that multiplier gives. Every slot takes the same number of cycles, so the run time is fixed.

Top module: `pixclk_search`

## Requirements
- R1: While reset is held and after it is released, `busy_o`, `done_o`, `pll_mult_o`, `post_div_o`, `dbl_o` and `none_o` are all 0.
- R2: `start_i` is accepted only while `busy_o` is low, and the accepting edge latches `target_khz_i`. A `start_i` raised while busy changes neither the result nor the run time.
- R3: `busy_o` is high from the accepting edge up to the completion cycle. `done_o` is high for exactly one cycle, `2*M_MAX*(2*(TGT_W+M_W)+5)+1` cycles after the accepting edge (1591 cycles with defaults). `busy_o` is low in that cycle.
- R4: For divider `m` on the plain path, the multiplier is `floor(m*target/3000)` and the candidate frequency is `floor(3000*n/m)` kHz.
- R5: A candidate counts only when its multiplier lies in 9..127 inclusive. A target of 1800 kHz gives `n=9, m=15`, and 1799 kHz gives no legal candidate.
- R6: The doubled path uses 6000 in place of 3000 and is considered only for odd `m`. A reported `dbl_o=1` always comes with an odd `post_div_o`.
- R7: Candidates are visited in the order m=15 plain, m=15 doubled, m=14 plain, down to m=1 doubled. A candidate replaces the best only if its error is strictly smaller, so on a tie the earlier one is kept (27000 kHz gives `n=126, m=14, dbl=0`).
- R8: The error is target minus candidate frequency. The reported setting has the smallest error among legal candidates, and `3000*(1+dbl)*n <= target*m` always holds.
- R9: If no candidate is legal, `none_o=1` and `pll_mult_o`, `post_div_o` and `dbl_o` are 0 (for example 1000 kHz or 1000000 kHz).
- R10: `pll_mult_o`, `post_div_o`, `dbl_o` and `none_o` change only on the edge that raises `done_o`, and hold between completions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Begin a search when idle |
| target_khz_i | input | TGT_W | Requested dot clock in kHz |
| busy_o | output | 1 | Search in progress |
| done_o | output | 1 | One-cycle completion strobe |
| pll_mult_o | output | N_W | Chosen multiplier n |
| post_div_o | output | M_W | Chosen divider m |
| dbl_o | output | 1 | Doubled 6 MHz path chosen |
| none_o | output | 1 | No legal candidate found |

## Verification
The assertions assume:
- `BASE_KHZ` and `M_MAX` are at least 1, so the shared divider never receives a zero divisor and its remainder-bound and carry checks stay meaningful.
- The overshoot check compares the result against the latched target, so it relies on the latch changing only on an accepted start.

The stimulus respects these assumptions:
- It holds reset for several cycles before the first start.
- It drives every input on the falling edge.
- It keeps targets within 20 bits.
- It sends one stray start in the middle of a run to show that the latch is left alone.

// File: rtl/pixclk_pkg.sv
`timescale 1ns/1ps
// Package pixclk_pkg
// Shared types for the pixel clock divider search.
// Assumes nothing beyond SystemVerilog 2017.
package pixclk_pkg;

    // Phases of one candidate slot plus idle/finish.
    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_ISSUE_A = 3'd1,   // load multiplier division
        ST_WAIT_A  = 3'd2,   // wait for multiplier quotient
        ST_ISSUE_B = 3'd3,   // load frequency division
        ST_WAIT_B  = 3'd4,   // wait for frequency quotient
        ST_JUDGE   = 3'd5,   // compare against best, advance
        ST_FIN     = 3'd6    // publish results
    } srch_state_t;

endpackage

// File: rtl/pixclk_rdiv.sv
`timescale 1ns/1ps
// Module pixclk_rdiv
// Unsigned restoring divider, one quotient bit per cycle.
// A load pulse captures dividend and divisor; ready_o returns high
// exactly W+1 cycles after the loading edge's following cycle count
// reaches zero (W steps after the load).
// Assumes: divisor is nonzero whenever a load is issued.
module pixclk_rdiv #(
    parameter int W = 24,
    localparam int CW = $clog2(W + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] dividend_i,
    input  logic [W-1:0] divisor_i,
    output logic [W-1:0] quot_o,
    output logic         ready_o
);

    logic [W-1:0]  rem_q;
    logic [W-1:0]  quo_q;
    logic [W-1:0]  dsr_q;
    logic [CW-1:0] cnt_q;

    logic [W:0]    trial;
    logic          fits;
    logic [W:0]    rem_nx;

    // Trial subtraction for the next quotient bit.
    always_comb begin
        trial  = {rem_q, quo_q[W-1]};
        fits   = (trial >= {1'b0, dsr_q});
        rem_nx = fits ? (trial - {1'b0, dsr_q}) : trial;
    end

    // Load operands or take one restoring step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q <= '0;
            quo_q <= '0;
            dsr_q <= '0;
            cnt_q <= '0;
        end else if (load_i) begin
            rem_q <= '0;
            quo_q <= dividend_i;
            dsr_q <= divisor_i;
            cnt_q <= CW'(W);
        end else if (cnt_q != '0) begin
            rem_q <= rem_nx[W-1:0];
            quo_q <= {quo_q[W-2:0], fits};
            cnt_q <= cnt_q - CW'(1);
        end
    end

    assign quot_o  = quo_q;
    assign ready_o = (cnt_q == '0);

    // R4
    rem_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dsr_q != '0) |-> (rem_q < dsr_q));

    // R4
    carry_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q != '0) |-> (rem_nx[W] == 1'b0));

endmodule

// File: rtl/pixclk_best.sv
`timescale 1ns/1ps
// Module pixclk_best
// Holds the best candidate seen so far in a search.
// A candidate offered with an error strictly below the stored one
// replaces it; ties keep the earlier candidate.
// Assumes: clear_i and offer_i are never high together.
module pixclk_best #(
    parameter int W   = 24,
    parameter int N_W = 7,
    parameter int M_W = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clear_i,
    input  logic           offer_i,
    input  logic [W-1:0]   diff_i,
    input  logic [N_W-1:0] n_i,
    input  logic [M_W-1:0] m_i,
    input  logic           dbl_i,
    output logic           found_o,
    output logic [N_W-1:0] n_o,
    output logic [M_W-1:0] m_o,
    output logic           dbl_o
);

    logic [W-1:0]   diff_q;
    logic [N_W-1:0] n_q;
    logic [M_W-1:0] m_q;
    logic           dbl_q;
    logic           found_q;
    logic           take;

    // Strict improvement test.
    assign take = offer_i && (diff_i < diff_q);

    // Reset/clear to "very large error", or adopt a better candidate.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            diff_q  <= '1;
            n_q     <= '0;
            m_q     <= '0;
            dbl_q   <= 1'b0;
            found_q <= 1'b0;
        end else if (take) begin
            diff_q  <= diff_i;
            n_q     <= n_i;
            m_q     <= m_i;
            dbl_q   <= dbl_i;
            found_q <= 1'b1;
        end
    end

    assign found_o = found_q;
    assign n_o     = n_q;
    assign m_o     = m_q;
    assign dbl_o   = dbl_q;

    // R7
    best_monotone_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clear_i |=> (diff_q <= $past(diff_q)));

    // R7
    tie_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (offer_i && !clear_i && (diff_i >= diff_q))
        |=> ($stable(m_q) && $stable(n_q) && $stable(dbl_q)));

endmodule

// File: rtl/pixclk_search.sv
`timescale 1ns/1ps
// Module pixclk_search
// Searches divider m from M_MAX down to 1, on the plain (BASE_KHZ) and
// doubled (2*BASE_KHZ) paths, for the PLL multiplier n giving the
// closest clock not above the target. Every slot has a fixed length,
// so a run always lasts 2*M_MAX*(2*W+5) cycles plus one finish cycle.
// Assumes: BASE_KHZ >= 1, M_MAX >= 1, synchronous active-low reset.
module pixclk_search
    import pixclk_pkg::*;
#(
    parameter int TGT_W    = 20,
    parameter int M_MAX    = 15,
    parameter int N_MIN    = 9,
    parameter int N_MAX    = 127,
    parameter int BASE_KHZ = 3000,
    localparam int M_W     = $clog2(M_MAX + 1),
    localparam int N_W     = $clog2(N_MAX + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [TGT_W-1:0] target_khz_i,
    output logic             busy_o,
    output logic             done_o,
    output logic [N_W-1:0]   pll_mult_o,
    output logic [M_W-1:0]   post_div_o,
    output logic             dbl_o,
    output logic             none_o
);

    localparam int W = TGT_W + M_W;

    srch_state_t    st_q;
    logic [TGT_W-1:0] tgt_q;
    logic [M_W-1:0] m_q;
    logic           dbl_q;
    logic [N_W-1:0] n_q;
    logic           legal_q;

    logic           div_load;
    logic [W-1:0]   div_dividend;
    logic [W-1:0]   div_divisor;
    logic [W-1:0]   div_quot;
    logic           div_ready;
    logic [W-1:0]   base_w;
    logic           n_fit;
    logic           path_ok;
    logic           offer;
    logic           accept;
    logic           last_slot;
    logic [W-1:0]   diff;

    logic           best_found;
    logic [N_W-1:0] best_n;
    logic [M_W-1:0] best_m;
    logic           best_dbl;

    // Operand selection for the shared divider and slot bookkeeping.
    always_comb begin
        base_w       = dbl_q ? W'(2 * BASE_KHZ) : W'(BASE_KHZ);
        div_load     = (st_q == ST_ISSUE_A) || (st_q == ST_ISSUE_B);
        div_dividend = (st_q == ST_ISSUE_A) ? (W'(m_q) * W'(tgt_q))
                                            : (base_w * W'(n_q));
        div_divisor  = (st_q == ST_ISSUE_A) ? base_w : W'(m_q);
        n_fit        = (div_quot >= W'(N_MIN)) && (div_quot <= W'(N_MAX));
        path_ok      = !dbl_q || m_q[0];
        offer        = (st_q == ST_JUDGE) && legal_q && path_ok;
        diff         = W'(tgt_q) - div_quot;
        last_slot    = dbl_q && (m_q == M_W'(1));
        accept       = (st_q == ST_IDLE) && start_i;
    end

    pixclk_rdiv #(.W(W)) u_div (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (div_load),
        .dividend_i (div_dividend),
        .divisor_i  (div_divisor),
        .quot_o     (div_quot),
        .ready_o    (div_ready)
    );

    pixclk_best #(.W(W), .N_W(N_W), .M_W(M_W)) u_best (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (accept),
        .offer_i (offer),
        .diff_i  (diff),
        .n_i     (n_q),
        .m_i     (m_q),
        .dbl_i   (dbl_q),
        .found_o (best_found),
        .n_o     (best_n),
        .m_o     (best_m),
        .dbl_o   (best_dbl)
    );

    // Sweep controller: walks slots m=M_MAX..1, plain then doubled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= ST_IDLE;
            tgt_q   <= '0;
            m_q     <= '0;
            dbl_q   <= 1'b0;
            n_q     <= '0;
            legal_q <= 1'b0;
        end else begin
            unique case (st_q)
                ST_IDLE: begin
                    if (start_i) begin
                        tgt_q <= target_khz_i;
                        m_q   <= M_W'(M_MAX);
                        dbl_q <= 1'b0;
                        st_q  <= ST_ISSUE_A;
                    end
                end
                ST_ISSUE_A: st_q <= ST_WAIT_A;
                ST_WAIT_A: begin
                    if (div_ready) begin
                        legal_q <= n_fit;
                        n_q     <= n_fit ? div_quot[N_W-1:0] : '0;
                        st_q    <= ST_ISSUE_B;
                    end
                end
                ST_ISSUE_B: st_q <= ST_WAIT_B;
                ST_WAIT_B: begin
                    if (div_ready) st_q <= ST_JUDGE;
                end
                ST_JUDGE: begin
                    if (last_slot) begin
                        st_q <= ST_FIN;
                    end else begin
                        if (dbl_q) begin
                            dbl_q <= 1'b0;
                            m_q   <= m_q - M_W'(1);
                        end else begin
                            dbl_q <= 1'b1;
                        end
                        st_q <= ST_ISSUE_A;
                    end
                end
                ST_FIN:  st_q <= ST_IDLE;
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    // Result registers and completion strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_o     <= 1'b0;
            pll_mult_o <= '0;
            post_div_o <= '0;
            dbl_o      <= 1'b0;
            none_o     <= 1'b0;
        end else if (st_q == ST_FIN) begin
            done_o     <= 1'b1;
            pll_mult_o <= best_found ? best_n : '0;
            post_div_o <= best_found ? best_m : '0;
            dbl_o      <= best_found && best_dbl;
            none_o     <= !best_found;
        end else begin
            done_o     <= 1'b0;
        end
    end

    assign busy_o = (st_q != ST_IDLE);

    // R3
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R2
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> $stable(tgt_q));

    // R5
    range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !none_o) |-> ((pll_mult_o >= N_W'(N_MIN)) &&
                                  (pll_mult_o <= N_W'(N_MAX)) &&
                                  (post_div_o != '0)));

    // R6
    dbl_odd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && dbl_o) |-> post_div_o[0]);

    // R8
    no_overshoot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !none_o) |->
        ((64'(pll_mult_o) * 64'(BASE_KHZ) * (dbl_o ? 64'd2 : 64'd1))
          <= (64'(tgt_q) * 64'(post_div_o))));

    // R9
    none_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && none_o) |-> ((pll_mult_o == '0) && (post_div_o == '0) && !dbl_o));

    // R10
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |=> (done_o || ($stable(pll_mult_o) && $stable(post_div_o) &&
                                 $stable(dbl_o) && $stable(none_o))));

endmodule

// File: tb/sim_pixclk_search.sv
`timescale 1ns/1ps
module sim_pixclk_search;

    localparam int LAT_K = 2 * 15 * (2 * 24 + 5);   // slot cycles before finish

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [19:0] target_khz_i = '0;
    logic        busy_o, done_o, dbl_o, none_o;
    logic [6:0]  pll_mult_o;
    logic [3:0]  post_div_o;

    int n_chk = 0;
    int n_bad = 0;
    bit chk_en = 1'b0;

    always #2 clk = ~clk;

    pixclk_search u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .target_khz_i(target_khz_i),
        .busy_o(busy_o), .done_o(done_o), .pll_mult_o(pll_mult_o),
        .post_div_o(post_div_o), .dbl_o(dbl_o), .none_o(none_o)
    );

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Behavioural search straight from the requirements.
    task automatic ref_search(input int t, output int rn, output int rm,
                              output int rd, output int rnone);
        int best;
        best = 32'h7fffffff;
        rn = 0; rm = 0; rd = 0;
        for (int m = 15; m >= 1; m--) begin
            int n;
            n = m * t / 3000;
            if (n >= 9 && n <= 127) begin
                int v;
                v = 3000 * n / m;
                if (t - v < best) begin best = t - v; rn = n; rm = m; rd = 0; end
            end
            if (m % 2 == 1) begin
                n = m * t / 6000;
                if (n >= 9 && n <= 127) begin
                    int v;
                    v = 6000 * n / m;
                    if (t - v < best) begin best = t - v; rn = n; rm = m; rd = 1; end
                end
            end
        end
        rnone = (rm == 0) ? 1 : 0;
    endtask

    // Cycle model: busy, done and held outputs.
    bit m_busy = 0, m_done = 0;
    int m_cnt = 0;
    int e_n = 0, e_m = 0, e_d = 0, e_none = 0;
    int p_n = 0, p_m = 0, p_d = 0, p_none = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0; m_done = 0; m_cnt = 0;
            e_n = 0; e_m = 0; e_d = 0; e_none = 0;
        end else begin
            m_done = 0;
            if (m_busy) begin
                if (m_cnt == LAT_K) begin
                    m_busy = 0; m_done = 1;
                    e_n = p_n; e_m = p_m; e_d = p_d; e_none = p_none;
                end else begin
                    m_cnt++;
                end
            end else if (start_i) begin
                m_busy = 1; m_cnt = 0;
                ref_search(int'(target_khz_i), p_n, p_m, p_d, p_none);
            end
        end
    end

    // Compare on every clock, away from the active edge.
    always @(negedge clk) begin
        if (chk_en) begin
            check(busy_o == m_busy, "R3 busy", busy_o, m_busy);
            check(done_o == m_done, "R3 done", done_o, m_done);
            check(pll_mult_o == e_n, "R10 mult", pll_mult_o, e_n);
            check(post_div_o == e_m, "R10 div", post_div_o, e_m);
            check(dbl_o == e_d, "R10 dbl", dbl_o, e_d);
            check(none_o == e_none, "R10 none", none_o, e_none);
        end
    end

    task automatic wait_done();
        for (int i = 0; i < LAT_K + 8; i++) begin
            @(negedge clk);
            if (done_o) break;
        end
    endtask

    task automatic check_result(input int t, input string tag);
        int rn, rm, rd, rnone;
        ref_search(t, rn, rm, rd, rnone);
        check(done_o == 1'b1, {tag, " done seen"}, done_o, 1);
        check(pll_mult_o == rn, {tag, " mult"}, pll_mult_o, rn);
        check(post_div_o == rm, {tag, " div"}, post_div_o, rm);
        check(dbl_o == rd, {tag, " dbl"}, dbl_o, rd);
        check(none_o == rnone, {tag, " none"}, none_o, rnone);
        // R6: doubled result needs odd divider
        check(!dbl_o || post_div_o[0], "R6 odd divider", post_div_o, 1);
        // R8: never above the target
        check(longint'(pll_mult_o) * 3000 * (dbl_o ? 2 : 1) <= longint'(t) * post_div_o,
              "R8 no overshoot", pll_mult_o, rn);
    endtask

    task automatic run_one(input int t, input string tag);
        @(negedge clk);
        start_i = 1'b1; target_khz_i = 20'(t);
        @(negedge clk);
        start_i = 1'b0;
        wait_done();
        check_result(t, tag);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        // R1: outputs idle while held in reset
        check(!busy_o && !done_o && pll_mult_o == 0 && post_div_o == 0 && !dbl_o && !none_o,
              "R1 in reset", busy_o, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy_o && !done_o && pll_mult_o == 0 && post_div_o == 0 && !none_o,
              "R1 after reset", busy_o, 0);
        chk_en = 1'b1;

        run_one(27000, "R7 tie keeps m14");
        check(post_div_o == 14 && pll_mult_o == 126, "R7 tie value", post_div_o, 14);
        run_one(1800, "R5 low edge");
        check(pll_mult_o == 9 && post_div_o == 15, "R5 n=9 legal", pll_mult_o, 9);
        run_one(1799, "R5 below edge");
        check(none_o == 1'b1, "R5 n=8 illegal", none_o, 1);
        run_one(1000, "R9 too low");
        run_one(1000000, "R9 too high");
        check(none_o && pll_mult_o == 0 && post_div_o == 0 && !dbl_o, "R9 zeros", pll_mult_o, 0);
        run_one(65000, "R4 plain 65000");
        run_one(25175, "R8 25175");
        run_one(148500, "R6 148500");
        run_one(74250, "R8 74250");
        run_one(108000, "R4 108000");
        run_one(40000, "R8 40000");
        run_one(381000, "R6 381000");
        run_one(33333, "R7 33333");

        // R2: stray start while busy leaves the run untouched
        @(negedge clk);
        start_i = 1'b1; target_khz_i = 20'd65000;
        @(negedge clk);
        start_i = 1'b0;
        repeat (200) @(negedge clk);
        start_i = 1'b1; target_khz_i = 20'd1000;
        @(negedge clk);
        start_i = 1'b0;
        check(busy_o == 1'b1, "R2 still busy", busy_o, 1);
        wait_done();
        check_result(65000, "R2 ignored start");

        repeat (5) @(negedge clk);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule